// File: doc/BRIEF.md
# Complex Gaussian Noise Generator with Saturating Injection

This block makes one complex Gaussian noise sample each time the sample strobe is high. Two 32-bit pseudo-random generators supply a pair of uniform draws. One draw sets a radius factor sqrt(-ln x1) and the other sets an angle 2π·x2. The I component is the radius factor times √2·cos of the angle. The Q component is the radius factor times √2·sin of the same angle. Both tables are computed at elaboration by constant functions.

The unscaled noise has a standard deviation of about 128 LSB. It is multiplied by an unsigned 16-bit amplitude with 16 fractional bits, and the result is scaled up by a fixed gain shift. The noise is then added to the complex input sample with saturating arithmetic. The scaled noise is also brought out on its own so that its power can be measured. Saturation of the scaled noise and saturation of the sum are flagged separately for I and for Q.

Top module: `awgn_gen`

## Requirements
- R1: While rst_ni is low, valid_o, all four data outputs and all four overflow flags are 0.
- R2: Each cycle with strobe_i high yields exactly one result, with valid_o high two clock edges later. Cycles without strobe_i yield no result. When valid_o is low, the data outputs and flags keep their previous values.
- R3: There are two uniform sources, A and B. Each is a 32-bit right-shifting Galois generator: the next state is (s >> 1) XOR (s[0] ? 0x80200003 : 0). A resets to 0x12345678 and B resets to 0x9E3779B9. On a strobe, the draw uses the current states and then each source advances one step. Index j1 is bits [31:24] of A, with the value 0 replaced by 1. Index j2 is bits [31:24] of B.
- R4: The radius factor is round(256·sqrt(-ln(j1/256))), with halves rounded away from zero.
- R5: The angle term for I is round(1024·√2·cos(2π·j2/256)). The angle term for Q uses the same table at index (j2 - 64) mod 256, which gives the sine branch.
- R6: The raw noise of each component is floor(radius·angle / 2048). Over many strobes it has a mean near 0 and a standard deviation near 128.
- R7: The scaled noise is floor(raw·amp / 256), clamped to the signed 16-bit range. noise_ovf_o bit 0 (I) or bit 1 (Q) is set when that component clamps. A clamped value is always the extreme of the same sign.
- R8: The sum is sig + scaled noise, clamped to the signed 16-bit range. sum_ovf_o bit 0 (I) or bit 1 (Q) is set when that component clamps. A positive clamp requires non-negative noise and a negative clamp requires negative noise.
- R9: With an amplitude of 0, both noise outputs are 0 and each sum equals the input signal sample.
- R10: The amplitude and both signal inputs are sampled only in the strobe cycle. Changes to them in other cycles do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Sample strobe, one noise draw per high cycle |
| amp_i | input | 16 | Unsigned noise amplitude, 0.16 format |
| sig_i_i | input | 16 | Signal input, I component, signed |
| sig_q_i | input | 16 | Signal input, Q component, signed |
| valid_o | output | 1 | High for one cycle when a new result is presented |
| sum_i_o | output | 16 | Signal plus noise, I component |
| sum_q_o | output | 16 | Signal plus noise, Q component |
| noise_i_o | output | 16 | Scaled noise alone, I component |
| noise_q_o | output | 16 | Scaled noise alone, Q component |
| noise_ovf_o | output | 2 | Scaled noise clamped, bit 0 I, bit 1 Q |
| sum_ovf_o | output | 2 | Sum clamped, bit 0 I, bit 1 Q |

## Verification
The following are checked on every cycle:
- The two-cycle strobe-to-valid latency.
- Output holding between results.
- The zero-amplitude pass-through.
- The rule that every clamped value is the full-scale extreme of the correct sign.

Only the bench scenarios can show the following:
- The exact noise values, which depend on the generator sequence and on both tables.
- That inputs changed between strobes are ignored.
- That the noise distribution has roughly zero mean and a 128 LSB spread.
- That heavy amplitudes drive both kinds of saturation.

// File: rtl/awgn_pkg.sv
package awgn_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int F_FRAC = 8;
  localparam int G_FRAC = 10;
  localparam int F_W    = F_FRAC + 3;
  localparam int G_W    = G_FRAC + 2;
  // unscaled noise std of 2^7 LSB
  localparam int RAW_SH = F_FRAC + G_FRAC - 7;
  localparam real PI_R  = 3.141592653589793;

  function automatic int round_away(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic int mag_code(int k, int idx_w);
    int  kk;
    real x;
    kk = (k == 0) ? 1 : k;
    x  = real'(kk) / real'(1 << idx_w);
    return round_away($sqrt(-$ln(x)) * real'(1 << F_FRAC));
  endfunction

  function automatic int cos_code(int k, int idx_w);
    real th;
    th = 2.0 * PI_R * real'(k) / real'(1 << idx_w);
    return round_away($sqrt(2.0) * $cos(th) * real'(1 << G_FRAC));
  endfunction
endpackage

// File: rtl/awgn_urng.sv
module awgn_urng #(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  timeunit 1ns; timeprecision 1ps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= SEED;
    else if (step_i) state_o <= (state_o >> 1) ^ (state_o[0] ? MASK : '0);
  end
endmodule

// File: rtl/awgn_bm_lut.sv
module awgn_bm_lut
  import awgn_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic        [IDX_W-1:0] x1_i,
  input  logic        [IDX_W-1:0] x2_i,
  output logic        [F_W-1:0]   mag_o,
  output logic signed [G_W-1:0]   cos_o,
  output logic signed [G_W-1:0]   sin_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int               DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] QTR   = IDX_W'(DEPTH / 4);

  logic        [F_W-1:0] mag_tab [DEPTH];
  logic signed [G_W-1:0] cos_tab [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    localparam int MV = mag_code(k, IDX_W);
    localparam int CV = cos_code(k, IDX_W);
    assign mag_tab[k] = F_W'(MV);
    assign cos_tab[k] = G_W'(CV);
  end

  logic [IDX_W-1:0] sin_idx;
  assign sin_idx = x2_i - QTR;   // cos(t - pi/2) = sin(t)

  assign mag_o = mag_tab[x1_i];
  assign cos_o = cos_tab[x2_i];
  assign sin_o = cos_tab[sin_idx];
endmodule

// File: rtl/awgn_comp.sv
module awgn_comp
  import awgn_pkg::*;
#(
  parameter int AMP_W   = 16,
  parameter int DW      = 16,
  parameter int GAIN_SH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [F_W-1:0]    mag_i,
  input  logic [G_W-1:0]    trig_i,
  input  logic [AMP_W-1:0]  amp_i,
  input  logic [DW-1:0]     sig_i,
  output logic [DW-1:0]     noise_o,
  output logic [DW-1:0]     sum_o,
  output logic              noise_ovf_o,
  output logic              sum_ovf_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PW    = F_W + G_W + 1;
  localparam int SW    = PW + AMP_W + 1;
  localparam int SC_SH = AMP_W - GAIN_SH;
  localparam logic signed [DW-1:0] D_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] D_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod, raw;
  logic signed [SW-1:0] scaled;
  logic signed [DW-1:0] n_sat, s_sat;
  logic signed [DW:0]   sum_full;
  logic                 n_ovf, s_ovf;

  always_comb begin
    prod   = PW'($signed({1'b0, mag_i})) * PW'($signed(trig_i));
    raw    = prod >>> RAW_SH;
    scaled = (SW'(raw) * SW'($signed({1'b0, amp_i}))) >>> SC_SH;
    n_ovf  = 1'b1;
    if (scaled > SW'(D_MAX))      n_sat = D_MAX;
    else if (scaled < SW'(D_MIN)) n_sat = D_MIN;
    else begin
      n_sat = scaled[DW-1:0];
      n_ovf = 1'b0;
    end
    sum_full = (DW+1)'($signed(sig_i)) + (DW+1)'(n_sat);
    s_ovf    = 1'b1;
    if (sum_full > (DW+1)'(D_MAX))      s_sat = D_MAX;
    else if (sum_full < (DW+1)'(D_MIN)) s_sat = D_MIN;
    else begin
      s_sat = sum_full[DW-1:0];
      s_ovf = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      noise_o     <= '0;
      sum_o       <= '0;
      noise_ovf_o <= 1'b0;
      sum_ovf_o   <= 1'b0;
    end else if (en_i) begin
      noise_o     <= n_sat;
      sum_o       <= s_sat;
      noise_ovf_o <= n_ovf;
      sum_ovf_o   <= s_ovf;
    end
  end
endmodule

// File: rtl/awgn_gen.sv
module awgn_gen
  import awgn_pkg::*;
#(
  parameter int            UW      = 32,
  parameter int            IDX_W   = 8,
  parameter int            DW      = 16,
  parameter int            AMP_W   = 16,
  parameter int            GAIN_SH = 8,
  parameter logic [UW-1:0] TAP_MASK = UW'(32'h8020_0003),
  parameter logic [UW-1:0] SEED_A   = UW'(32'h1234_5678),
  parameter logic [UW-1:0] SEED_B   = UW'(32'h9E37_79B9)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [DW-1:0]    sig_i_i,
  input  logic [DW-1:0]    sig_q_i,
  output logic             valid_o,
  output logic [DW-1:0]    sum_i_o,
  output logic [DW-1:0]    sum_q_o,
  output logic [DW-1:0]    noise_i_o,
  output logic [DW-1:0]    noise_q_o,
  output logic [1:0]       noise_ovf_o,
  output logic [1:0]       sum_ovf_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NC = 2;

  logic [UW-1:0]    st_a, st_b;
  logic [IDX_W-1:0] x1, x2;
  logic [F_W-1:0]   mag_w;
  logic [G_W-1:0]   trig_w [NC];

  awgn_urng #(.W(UW), .MASK(TAP_MASK), .SEED(SEED_A)) u_src_a (
    .clk_i, .rst_ni, .step_i(strobe_i), .state_o(st_a));
  awgn_urng #(.W(UW), .MASK(TAP_MASK), .SEED(SEED_B)) u_src_b (
    .clk_i, .rst_ni, .step_i(strobe_i), .state_o(st_b));

  // x1 = 0 would make -ln undefined: use smallest nonzero code
  assign x1 = (st_a[UW-1 -: IDX_W] == '0) ? IDX_W'(1) : st_a[UW-1 -: IDX_W];
  assign x2 = st_b[UW-1 -: IDX_W];

  awgn_bm_lut #(.IDX_W(IDX_W)) u_lut (
    .x1_i(x1), .x2_i(x2), .mag_o(mag_w), .cos_o(trig_w[0]), .sin_o(trig_w[1]));

  // stage 1: capture draw and operands
  logic             v1_q;
  logic [F_W-1:0]   mag_q;
  logic [G_W-1:0]   trig_q [NC];
  logic [AMP_W-1:0] amp_q;
  logic [DW-1:0]    sig_q  [NC];
  logic [DW-1:0]    sig_in [NC];

  assign sig_in[0] = sig_i_i;
  assign sig_in[1] = sig_q_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      mag_q <= '0;
      amp_q <= '0;
      for (int c = 0; c < NC; c++) begin
        trig_q[c] <= '0;
        sig_q[c]  <= '0;
      end
    end else begin
      v1_q <= strobe_i;
      if (strobe_i) begin
        mag_q <= mag_w;
        amp_q <= amp_i;
        for (int c = 0; c < NC; c++) begin
          trig_q[c] <= trig_w[c];
          sig_q[c]  <= sig_in[c];
        end
      end
    end
  end

  // stage 2: per-component scale, clamp, add
  logic [DW-1:0] noise_w [NC];
  logic [DW-1:0] sum_w   [NC];

  for (genvar c = 0; c < NC; c++) begin : g_comp
    awgn_comp #(.AMP_W(AMP_W), .DW(DW), .GAIN_SH(GAIN_SH)) u_comp (
      .clk_i, .rst_ni, .en_i(v1_q),
      .mag_i(mag_q), .trig_i(trig_q[c]), .amp_i(amp_q), .sig_i(sig_q[c]),
      .noise_o(noise_w[c]), .sum_o(sum_w[c]),
      .noise_ovf_o(noise_ovf_o[c]), .sum_ovf_o(sum_ovf_o[c]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= v1_q;
  end

  assign noise_i_o = noise_w[0];
  assign noise_q_o = noise_w[1];
  assign sum_i_o   = sum_w[0];
  assign sum_q_o   = sum_w[1];
endmodule

// File: rtl/awgn_gen_chk.sv
module awgn_gen_chk #(
  parameter int DW    = 16,
  parameter int AMP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             strobe_i,
  input logic [AMP_W-1:0] amp_i,
  input logic [DW-1:0]    sig_i_i,
  input logic [DW-1:0]    sig_q_i,
  input logic             valid_o,
  input logic [DW-1:0]    sum_i_o,
  input logic [DW-1:0]    sum_q_o,
  input logic [DW-1:0]    noise_i_o,
  input logic [DW-1:0]    noise_q_o,
  input logic [1:0]       noise_ovf_o,
  input logic [1:0]       sum_ovf_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [DW-1:0] D_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] D_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (valid_o == $past(strobe_i, 2)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1 && !valid_o) |->
      ($stable(noise_i_o) && $stable(noise_q_o) && $stable(sum_i_o) && $stable(sum_q_o)));

  p_zero_amp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && valid_o && $past(amp_i, 2) == '0) |->
      (noise_i_o == '0 && noise_q_o == '0 &&
       sum_i_o == $past(sig_i_i, 2) && sum_q_o == $past(sig_q_i, 2)));

  p_noise_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (noise_ovf_o[0] |-> (noise_i_o == D_MAX || noise_i_o == D_MIN)) and
    (noise_ovf_o[1] |-> (noise_q_o == D_MAX || noise_q_o == D_MIN)));

  p_sum_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_ovf_o[0] |-> ((sum_i_o == D_MAX && !noise_i_o[DW-1]) ||
                       (sum_i_o == D_MIN &&  noise_i_o[DW-1]))) and
    (sum_ovf_o[1] |-> ((sum_q_o == D_MAX && !noise_q_o[DW-1]) ||
                       (sum_q_o == D_MIN &&  noise_q_o[DW-1]))));
endmodule

bind awgn_gen awgn_gen_chk #(.DW(DW), .AMP_W(AMP_W)) u_chk (.*);

// File: tb/tb_awgn_gen.sv
module tb_awgn_gen;
  timeunit 1ns; timeprecision 1ps;

  localparam longint MASK = 64'h8020_0003;
  localparam real    PI_B = 3.141592653589793;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        strobe_i = 1'b0;
  logic [15:0] amp_i = '0;
  logic [15:0] sig_i_i = '0, sig_q_i = '0;
  logic        valid_o;
  logic [15:0] sum_i_o, sum_q_o, noise_i_o, noise_q_o;
  logic [1:0]  noise_ovf_o, sum_ovf_o;

  awgn_gen dut (.*);

  always #4 clk_i = ~clk_i;   // 125 MHz

  int checks = 0, errors = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(0.5 - v);
  endfunction

  function automatic longint clamp16(longint v, output bit o);
    o = 1'b1;
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    o = 1'b0;
    return v;
  endfunction

  // reference model
  longint src_a, src_b, cyc;
  longint q_due[$], q_ni[$], q_nq[$], q_si[$], q_sq[$];
  int     q_fl[$];
  bit     cmp_en = 1'b0;

  function automatic longint step_src(longint s);
    longint n;
    n = s >> 1;
    if (s[0]) n = n ^ MASK;
    return n;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_a = 64'h1234_5678;
      src_b = 64'h9E37_79B9;
      cyc   = 0;
      q_due.delete(); q_ni.delete(); q_nq.delete();
      q_si.delete();  q_sq.delete(); q_fl.delete();
    end else begin
      cyc++;
      if (strobe_i) begin
        int j1, j2, jq, f, gi, gq;
        longint raw_i, raw_q, ni, nq, si, sq;
        bit o0, o1, o2, o3;
        j1 = int'(src_a[31:24]); if (j1 == 0) j1 = 1;
        j2 = int'(src_b[31:24]);
        jq = (j2 - 64) & 255;
        f  = rnd($sqrt(-$ln(real'(j1) / 256.0)) * 256.0);
        gi = rnd(1024.0 * $sqrt(2.0) * $cos(2.0 * PI_B * real'(j2) / 256.0));
        gq = rnd(1024.0 * $sqrt(2.0) * $cos(2.0 * PI_B * real'(jq) / 256.0));
        raw_i = (longint'(f) * gi) >>> 11;
        raw_q = (longint'(f) * gq) >>> 11;
        ni = clamp16((raw_i * longint'(amp_i)) >>> 8, o0);
        nq = clamp16((raw_q * longint'(amp_i)) >>> 8, o1);
        si = clamp16(longint'($signed(sig_i_i)) + ni, o2);
        sq = clamp16(longint'($signed(sig_q_i)) + nq, o3);
        q_due.push_back(cyc + 1);
        q_ni.push_back(ni); q_nq.push_back(nq);
        q_si.push_back(si); q_sq.push_back(sq);
        q_fl.push_back({o3, o2, o1, o0});
        src_a = step_src(src_a);
        src_b = step_src(src_b);
      end
    end
  end

  // statistics and saturation counters
  bit     stat_en = 1'b0;
  int     n_stat = 0, n_novf = 0, n_sovf = 0;
  real    s1i = 0, s2i = 0, s1q = 0, s2q = 0;

  always @(negedge clk_i) begin
    if (rst_ni && cmp_en) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk("R2 valid", valid_o, 1);
        chk("R3 R4 R5 R6 R7 noise_i", $signed(noise_i_o), q_ni[0]);
        chk("R3 R4 R5 R6 R7 noise_q", $signed(noise_q_o), q_nq[0]);
        chk("R8 R10 sum_i", $signed(sum_i_o), q_si[0]);
        chk("R8 R10 sum_q", $signed(sum_q_o), q_sq[0]);
        chk("R7 R8 flags", {sum_ovf_o, noise_ovf_o}, q_fl[0]);
        if (noise_ovf_o != 0) n_novf++;
        if (sum_ovf_o != 0)   n_sovf++;
        if (stat_en) begin
          real vi, vq;
          vi = real'($signed(noise_i_o)); vq = real'($signed(noise_q_o));
          s1i += vi; s2i += vi * vi; s1q += vq; s2q += vq * vq;
          n_stat++;
        end
        void'(q_due.pop_front()); void'(q_ni.pop_front()); void'(q_nq.pop_front());
        void'(q_si.pop_front());  void'(q_sq.pop_front()); void'(q_fl.pop_front());
      end else begin
        chk("R2 no result", valid_o, 0);
      end
    end
  end

  task automatic drive(bit s, int amp, int si, int sq);
    @(negedge clk_i);
    strobe_i = s;
    amp_i    = 16'(amp);
    sig_i_i  = 16'(si);
    sig_q_i  = 16'(sq);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL R2 watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    // R1: reset state
    chk("R1 valid", valid_o, 0);
    chk("R1 noise_i", noise_i_o, 0);
    chk("R1 noise_q", noise_q_o, 0);
    chk("R1 sum_i", sum_i_o, 0);
    chk("R1 sum_q", sum_q_o, 0);
    chk("R1 flags", {sum_ovf_o, noise_ovf_o}, 0);
    rst_ni  = 1'b1;
    cmp_en  = 1'b1;

    // R2: idle cycles produce nothing
    repeat (5) drive(0, 256, 100, -100);

    // R6: unit gain, statistics
    stat_en = 1'b1;
    for (int i = 0; i < 4000; i++) drive(1, 256, (i * 37) % 2000 - 1000, 500 - (i * 13) % 1000);
    drive(0, 256, 0, 0);
    drive(0, 256, 0, 0);
    stat_en = 1'b0;

    // R9: zero amplitude passes the signal through
    for (int i = 0; i < 40; i++) drive(1, 0, 32767 - i * 1000, -32768 + i * 999);

    // R7 R8: full amplitude near full scale
    for (int i = 0; i < 300; i++) drive(1, 16'hFFFF, (i % 2) ? 32000 : -32000, (i % 3) ? -31000 : 31000);

    // R10: sparse strobes, inputs change between them
    for (int i = 0; i < 200; i++) begin
      drive(1, 100 + i * 7, i * 50, -i * 50);
      drive(0, 16'hFFFF, 32767, -32768);
      drive(0, 0, -32768, 32767);
    end
    repeat (4) drive(0, 0, 0, 0);

    chk("R2 queue drained", q_due.size(), 0);
    chk("R7 noise clamping seen", (n_novf > 0), 1);
    chk("R8 sum clamping seen", (n_sovf > 0), 1);
    begin
      real mi, mq, sdi, sdq;
      mi  = s1i / n_stat;  mq = s1q / n_stat;
      sdi = $sqrt(s2i / n_stat - mi * mi);
      sdq = $sqrt(s2q / n_stat - mq * mq);
      chk("R6 mean I near 0", (mi > -12.0 && mi < 12.0), 1);
      chk("R6 mean Q near 0", (mq > -12.0 && mq < 12.0), 1);
      chk("R6 std I near 128", (sdi > 105.0 && sdi < 150.0), 1);
      chk("R6 std Q near 128", (sdq > 105.0 && sdq < 150.0), 1);
    end
    finish_run();
  end
endmodule